// File: doc/BRIEF.md
# Receive Statistics and Latency Collector

This block terminates the receive path of a hardware traffic tester. Packets arrive as a word stream with valid, start-of-packet, end-of-packet and a per-beat byte count. The first word of every packet carries a one-byte class field. Control and configuration traffic is handed straight on to the downstream stage. Data plane test traffic is consumed here: it is counted, timed and optionally captured.

Each data packet is stamped when its first word arrives. The stamp comes from a free-running nanosecond counter that the block also drives out, so the transmit side stamps against the same time base. The transmit stamp that the sender placed in the packet is subtracted from the arrival stamp to give the forwarding latency. Running totals (packets, bytes, latency sum, minimum and maximum) are read through a small register port. One packet in every N can be copied into a slotted sample memory for later inspection.

Top module: `rxs_collector`

## Requirements
- R1: A packet is a data packet when bits [7:0] of its first word equal 0x00. Any other value, including 0x01 and 0xFF, marks it as control/configuration.
- R2: Every beat of a control packet appears on the out_* ports one clock later, with data, sop, eop and byte count unchanged. Control packets leave every counter and the sample memory untouched. Data packets never appear on out_valid.
- R3: time_ns is 48 bits wide, is 0 in reset and advances by NS_PER_CLK (default 20) on every clock.
- R4: A data packet's arrival stamp is the time_ns value in the cycle of its first beat. Its transmit stamp is {word1[15:0], word2[31:0]}, and its latency is arrival minus transmit modulo 2^48. Data packets carry at least 3 words.
- R5: At the last beat of each data packet, the packet counter increments by one and the byte counter grows by the sum of in_nbytes over all beats of that packet.
- R6: The 64-bit latency sum adds each data packet's latency. The 48-bit minimum starts at all ones and the 48-bit maximum starts at 0; they track the smallest and largest latency seen.
- R7: With sample_n = N > 0, the first data packet after reset or clear is sampled, then every Nth data packet after it. With N = 0, nothing is sampled.
- R8: Word k (k < 64) of the packet in slot s is stored at sample address s*64+k. Words past 63 are not stored. smp_rdata returns the addressed word one clock after smp_addr is presented. The fill count reports the number of slots in use.
- R9: Once 8 slots are filled, further sampling is ignored and the fill count stays at 8 until a clear. After a clear, sampling restarts at slot 0.
- R10: A one-cycle clr sets the packet, byte and sum counters, the maximum and the fill count to 0, the minimum to all ones, and restarts the 1-in-N phase. A clear in the same cycle as a data packet's last beat wins, and that packet is not counted.
- R11: reg_rdata shows, one clock after reg_addr is presented, the packets (0), bytes (1), latency sum (2), latency minimum (3), latency maximum (4) or fill count (5), zero-extended to 64 bits. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_data | input | 32 | Input word |
| in_nbytes | input | 3 | Valid bytes in this beat (1..4) |
| out_valid | output | 1 | Forwarded control beat valid |
| out_sop | output | 1 | Forwarded first beat |
| out_eop | output | 1 | Forwarded last beat |
| out_data | output | 32 | Forwarded word |
| out_nbytes | output | 3 | Forwarded byte count |
| time_ns | output | 48 | Shared nanosecond time base |
| clr | input | 1 | Clear all statistics and samples |
| sample_n | input | 8 | Sampling ratio N (0 disables) |
| reg_addr | input | 3 | Statistics register select |
| reg_rdata | output | 64 | Registered statistics read data |
| smp_addr | input | 9 | Sample memory read address |
| smp_rdata | output | 32 | Registered sample memory data |

## Verification
The assertions assume well-formed framing: every packet opens with sop, closes with eop and keeps valid asserted between. Data packets are at least three words long so the transmit stamp is complete. sample_n is held steady while a packet is in flight. The stimulus sends whole packets only, with back-to-back beats from a task that always builds the class word, the split transmit stamp and the byte counts this way, and it changes sample_n only between packets. Clears are issued either between packets or, in one case, on purpose in the last beat of a data packet.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic [2:0] {
    RA_PKTS  = 3'd0,
    RA_BYTES = 3'd1,
    RA_LSUM  = 3'd2,
    RA_LMIN  = 3'd3,
    RA_LMAX  = 3'd4,
    RA_FILL  = 3'd5
  } reg_addr_e;

  localparam int CNT_W = 64;
endpackage

// File: rtl/rxs_classify.sv
module rxs_classify #(
  parameter int DW  = 32,
  parameter int NBW = 3,
  parameter int IW  = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           in_sop,
  input  logic           in_eop,
  input  logic [DW-1:0]  in_data,
  input  logic [NBW-1:0] in_nbytes,
  output logic           out_valid,
  output logic           out_sop,
  output logic           out_eop,
  output logic [DW-1:0]  out_data,
  output logic [NBW-1:0] out_nbytes,
  output logic           data_beat,
  output logic [IW-1:0]  idx_now
);
  localparam logic [IW-1:0] IDX_MAX = '1;

  logic          ctrl_q, ctrl_now;
  logic [IW-1:0] idx_q;

  // class byte is only looked at on the first beat, then held for the packet
  assign ctrl_now  = in_sop ? (in_data[7:0] != 8'h00) : ctrl_q;
  assign data_beat = in_valid && !ctrl_now;
  assign idx_now   = in_sop ? '0 : idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= 1'b0;
      idx_q      <= '0;
      out_valid  <= 1'b0;
      out_sop    <= 1'b0;
      out_eop    <= 1'b0;
      out_data   <= '0;
      out_nbytes <= '0;
    end else begin
      out_valid <= in_valid && ctrl_now;
      if (in_valid) begin
        ctrl_q     <= ctrl_now;
        idx_q      <= (idx_now == IDX_MAX) ? IDX_MAX : idx_now + 1'b1;
        out_sop    <= in_sop;
        out_eop    <= in_eop;
        out_data   <= in_data;
        out_nbytes <= in_nbytes;
      end
    end
  end

  p_pass_follows_input_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
endmodule

// File: rtl/rxs_stats.sv
module rxs_stats #(
  parameter int DW  = 32,
  parameter int NBW = 3,
  parameter int IW  = 7,
  parameter int TSW = 48
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     dv,
  input  logic                     sop,
  input  logic                     eop,
  input  logic [IW-1:0]            idx,
  input  logic [DW-1:0]            data,
  input  logic [NBW-1:0]           nbytes,
  input  logic [TSW-1:0]           now,
  output logic [rxs_pkg::CNT_W-1:0] pkts,
  output logic [rxs_pkg::CNT_W-1:0] bytes,
  output logic [rxs_pkg::CNT_W-1:0] lsum,
  output logic [TSW-1:0]           lmin,
  output logic [TSW-1:0]           lmax
);
  localparam int HIW = TSW - DW;
  localparam int PBW = 16;

  logic [TSW-1:0] stamp_q, lat_q, lat_now, lat_use;
  logic [HIW-1:0] tshi_q;
  logic [PBW-1:0] bacc_q, bytes_pkt;

  assign lat_now   = stamp_q - {tshi_q, data};
  assign lat_use   = (idx == IW'(2)) ? lat_now : lat_q;
  assign bytes_pkt = (sop ? '0 : bacc_q) + PBW'(nbytes);

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_q <= '0;
      tshi_q  <= '0;
      lat_q   <= '0;
      bacc_q  <= '0;
    end else if (dv) begin
      bacc_q <= bytes_pkt;
      if (sop)            stamp_q <= now;
      if (idx == IW'(1))  tshi_q  <= data[HIW-1:0];
      if (idx == IW'(2))  lat_q   <= lat_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pkts  <= '0;
      bytes <= '0;
      lsum  <= '0;
      lmin  <= '1;
      lmax  <= '0;
    end else if (dv && eop) begin
      pkts  <= pkts + 1'b1;
      bytes <= bytes + rxs_pkg::CNT_W'(bytes_pkt);
      lsum  <= lsum + rxs_pkg::CNT_W'(lat_use);
      if (lat_use < lmin) lmin <= lat_use;
      if (lat_use > lmax) lmax <= lat_use;
    end
  end

  p_pkt_step_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(clr) |-> (pkts == $past(pkts) || pkts == $past(pkts) + 1'b1));
  p_min_le_max_r6: assert property (@(posedge clk) disable iff (rst)
    (pkts != '0) |-> (lmin <= lmax));
  p_clear_zeroes_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pkts == '0 && lsum == '0 && lmin == '1));
endmodule

// File: rtl/rxs_sampler.sv
module rxs_sampler #(
  parameter int DW    = 32,
  parameter int IW    = 7,
  parameter int NW    = 8,
  parameter int SLOTS = 8,
  parameter int WORDS = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clr,
  input  logic                           dv,
  input  logic                           sop,
  input  logic                           eop,
  input  logic [IW-1:0]                  idx,
  input  logic [DW-1:0]                  data,
  input  logic [NW-1:0]                  ratio,
  input  logic [$clog2(SLOTS*WORDS)-1:0] rd_addr,
  output logic [DW-1:0]                  rd_data,
  output logic [$clog2(SLOTS+1)-1:0]     fill
);
  localparam int SW    = $clog2(SLOTS);
  localparam int WW    = $clog2(WORDS);
  localparam int DEPTH = SLOTS * WORDS;
  localparam int FW    = $clog2(SLOTS + 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [NW-1:0]    phase_q;
  logic             take_q, take_now, wr_en;
  logic [SW+WW-1:0] wr_addr;
  logic [NW:0]      phase_inc;

  assign take_now  = sop ? (ratio != '0 && phase_q == '0 && fill < FW'(SLOTS)) : take_q;
  assign wr_en     = dv && take_now && (idx < IW'(WORDS));
  assign wr_addr   = {fill[SW-1:0], idx[WW-1:0]};
  assign phase_inc = {1'b0, phase_q} + 1'b1;

  // plain write port and registered read port so the array maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fill    <= '0;
      phase_q <= '0;
      take_q  <= 1'b0;
    end else if (dv) begin
      take_q <= take_now;
      if (eop) begin
        if (take_now) fill <= fill + 1'b1;
        phase_q <= (phase_inc >= {1'b0, ratio}) ? '0 : phase_inc[NW-1:0];
      end
    end
  end

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (rst)
    fill <= FW'(SLOTS));
  p_full_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (fill == FW'(SLOTS) && !clr) |=> fill == FW'(SLOTS));
  p_fill_step_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(clr) |-> (fill == $past(fill) || fill == $past(fill) + 1'b1));
endmodule

// File: rtl/rxs_collector.sv
module rxs_collector #(
  parameter int DW         = 32,
  parameter int NBW        = 3,
  parameter int TSW        = 48,
  parameter int NS_PER_CLK = 20,
  parameter int NW         = 8,
  parameter int SLOTS      = 8,
  parameter int WORDS      = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sop,
  input  logic                 in_eop,
  input  logic [DW-1:0]        in_data,
  input  logic [NBW-1:0]       in_nbytes,
  output logic                 out_valid,
  output logic                 out_sop,
  output logic                 out_eop,
  output logic [DW-1:0]        out_data,
  output logic [NBW-1:0]       out_nbytes,
  output logic [TSW-1:0]       time_ns,
  input  logic                 clr,
  input  logic [NW-1:0]        sample_n,
  input  logic [2:0]           reg_addr,
  output logic [63:0]          reg_rdata,
  input  logic [8:0]           smp_addr,
  output logic [DW-1:0]        smp_rdata
);
  import rxs_pkg::*;

  localparam int IW = $clog2(WORDS) + 1;
  localparam int FW = $clog2(SLOTS + 1);

  logic                 data_beat;
  logic [IW-1:0]        idx_now;
  logic [CNT_W-1:0]     pkts, bytes, lsum;
  logic [TSW-1:0]       lmin, lmax;
  logic [FW-1:0]        fill;

  always_ff @(posedge clk) begin
    if (rst) time_ns <= '0;
    else     time_ns <= time_ns + TSW'(NS_PER_CLK);
  end

  rxs_classify #(.DW(DW), .NBW(NBW), .IW(IW)) u_cls (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .in_nbytes(in_nbytes),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
    .out_data(out_data), .out_nbytes(out_nbytes),
    .data_beat(data_beat), .idx_now(idx_now)
  );

  rxs_stats #(.DW(DW), .NBW(NBW), .IW(IW), .TSW(TSW)) u_st (
    .clk(clk), .rst(rst), .clr(clr),
    .dv(data_beat), .sop(in_sop), .eop(in_eop), .idx(idx_now),
    .data(in_data), .nbytes(in_nbytes), .now(time_ns),
    .pkts(pkts), .bytes(bytes), .lsum(lsum), .lmin(lmin), .lmax(lmax)
  );

  rxs_sampler #(.DW(DW), .IW(IW), .NW(NW), .SLOTS(SLOTS), .WORDS(WORDS)) u_smp (
    .clk(clk), .rst(rst), .clr(clr),
    .dv(data_beat), .sop(in_sop), .eop(in_eop), .idx(idx_now),
    .data(in_data), .ratio(sample_n),
    .rd_addr(smp_addr[$clog2(SLOTS*WORDS)-1:0]), .rd_data(smp_rdata),
    .fill(fill)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        RA_PKTS:  reg_rdata <= pkts;
        RA_BYTES: reg_rdata <= bytes;
        RA_LSUM:  reg_rdata <= lsum;
        RA_LMIN:  reg_rdata <= 64'(lmin);
        RA_LMAX:  reg_rdata <= 64'(lmax);
        RA_FILL:  reg_rdata <= 64'(fill);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  p_time_step_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> time_ns == TSW'($past(time_ns) + TSW'(NS_PER_CLK)));
  p_ctrl_only_out_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop && in_data[7:0] == 8'h00) |=> !out_valid);
endmodule

// File: tb/sim_rxs_collector.sv
module sim_rxs_collector;
  logic        clk = 0, rst = 1;
  logic        in_valid = 0, in_sop = 0, in_eop = 0, clr = 0;
  logic [31:0] in_data = '0;
  logic [2:0]  in_nbytes = '0, reg_addr = '0;
  logic [7:0]  sample_n = '0;
  logic [8:0]  smp_addr = '0;
  logic        out_valid, out_sop, out_eop;
  logic [31:0] out_data, smp_rdata;
  logic [2:0]  out_nbytes;
  logic [47:0] time_ns;
  logic [63:0] reg_rdata;

  int n_chk = 0, n_bad = 0;

  // expected model
  longint unsigned m_pkts, m_bytes, m_sum;
  logic [47:0] m_min, m_max;
  int m_fill, m_phase;
  logic [31:0] exp_mem [8][64];

  // {type[47:40], nwords[39:32], lastbytes[31:29], latency[28:0]}
  localparam logic [47:0] VEC [8] = '{
    {8'h00, 8'd3,  3'd4, 29'd100},
    {8'h3C, 8'd2,  3'd2, 29'd0},
    {8'h00, 8'd5,  3'd1, 29'd37},
    {8'h00, 8'd70, 3'd2, 29'd5000},
    {8'h01, 8'd1,  3'd4, 29'd0},
    {8'h00, 8'd4,  3'd3, 29'd0},
    {8'h00, 8'd3,  3'd4, 29'd1},
    {8'hFF, 8'd3,  3'd4, 29'd0}
  };

  rxs_collector u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .in_nbytes(in_nbytes), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
    .out_nbytes(out_nbytes), .time_ns(time_ns), .clr(clr), .sample_n(sample_n),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .smp_addr(smp_addr),
    .smp_rdata(smp_rdata)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_pkts = 0; m_bytes = 0; m_sum = 0;
    m_min = '1; m_max = '0; m_fill = 0; m_phase = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] v);
    @(negedge clk) reg_addr = a;
    @(posedge clk) #1 v = reg_rdata;
  endtask

  task automatic rds(input int a, output logic [31:0] v);
    @(negedge clk) smp_addr = 9'(a);
    @(posedge clk) #1 v = smp_rdata;
  endtask

  task automatic pulse_clear();
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
    model_clear();
  endtask

  // sends one packet; clr_last raises clr during the final beat
  task automatic send(input logic [7:0] typ, input int nw, input int lastb,
                      input logic [47:0] lat, input int id, input bit clr_last);
    logic [47:0] v, tx;
    logic [31:0] w;
    bit ctrl, take;
    int nbytes_tot;
    ctrl = (typ != 8'h00);
    take = !ctrl && sample_n != 0 && m_phase == 0 && m_fill < 8;
    nbytes_tot = 0;
    v = '0; tx = '0;
    for (int k = 0; k < nw; k++) begin
      @(negedge clk);
      if (k == 0) begin
        v  = time_ns;
        tx = v - lat;
      end
      case (k)
        0: w = {8'(id), 8'hA5, 8'h5A, typ};
        1: w = {8'(id), 8'h11, tx[47:32]};
        2: w = tx[31:0];
        default: w = {8'(id), 8'(k), 16'hC0DE};
      endcase
      in_valid = 1; in_sop = (k == 0); in_eop = (k == nw - 1);
      in_data = w;
      in_nbytes = (k == nw - 1) ? 3'(lastb) : 3'd4;
      nbytes_tot += int'(in_nbytes);
      clr = clr_last && (k == nw - 1);
      if (take && k < 64) exp_mem[m_fill][k] = w;
      @(posedge clk) #1;
      if (ctrl)
        chk(out_valid && out_data == w && out_sop == (k == 0) &&
            out_eop == (k == nw - 1) && out_nbytes == 3'((k == nw - 1) ? lastb : 4),
            "R2 passthrough", {31'd0, out_valid, out_data}, {32'd1, w});
      else
        chk(!out_valid, "R2 data not forwarded", 64'(out_valid), 64'd0);
    end
    @(negedge clk) in_valid = 0; in_sop = 0; in_eop = 0; clr = 0;
    if (clr_last) model_clear();
    else if (!ctrl) begin
      m_pkts++; m_bytes += longint'(nbytes_tot); m_sum += longint'(lat);
      if (lat < m_min) m_min = lat;
      if (lat > m_max) m_max = lat;
      if (take) m_fill++;
      m_phase = (m_phase + 1 >= int'(sample_n)) ? 0 : m_phase + 1;
    end
  endtask

  task automatic check_regs(input string tag);
    logic [63:0] v;
    rd(3'd0, v); chk(v == m_pkts,  {tag, " R5 pkts"},  v, m_pkts);
    rd(3'd1, v); chk(v == m_bytes, {tag, " R5 bytes"}, v, m_bytes);
    rd(3'd2, v); chk(v == m_sum,   {tag, " R6 sum"},   v, m_sum);
    rd(3'd3, v); chk(v == 64'(m_min), {tag, " R6 min"}, v, 64'(m_min));
    rd(3'd4, v); chk(v == 64'(m_max), {tag, " R6 max"}, v, 64'(m_max));
    rd(3'd5, v); chk(v == 64'(m_fill), {tag, " R8 fill"}, v, 64'(m_fill));
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [31:0] s;
    logic [47:0] t0;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 0;

    // reset state, R11 map and unused address
    check_regs("reset R11");
    rd(3'd7, v); chk(v == 0, "R11 unused address", v, 0);
    chk(!out_valid, "R2 idle output", 64'(out_valid), 0);
    @(negedge clk) t0 = time_ns;
    @(negedge clk) chk(time_ns - t0 == 48'd20, "R3 time step", 64'(time_ns - t0), 20);

    // vector table walk, 1-in-2 sampling
    sample_n = 8'd2;
    foreach (VEC[i]) begin
      send(VEC[i][47:40], int'(VEC[i][39:32]), int'(VEC[i][31:29]),
           48'(VEC[i][28:0]), i, 0);
      check_regs($sformatf("R1 R4 vec%0d", i));
    end
    // sampled packets: vec0 -> slot0, vec3 -> slot1 (70 words), vec6 -> slot2
    for (int sl = 0; sl < 3; sl++) begin
      rds(sl * 64, s);      chk(s == exp_mem[sl][0], "R8 slot word0", 64'(s), 64'(exp_mem[sl][0]));
      rds(sl * 64 + 2, s);  chk(s == exp_mem[sl][2], "R8 slot word2", 64'(s), 64'(exp_mem[sl][2]));
    end
    rds(64 + 63, s); chk(s == exp_mem[1][63], "R8 last stored word", 64'(s), 64'(exp_mem[1][63]));

    // R10 clear
    pulse_clear();
    check_regs("R10 after clear");

    // R7 N=0 disables sampling
    sample_n = 8'd0;
    send(8'h00, 3, 4, 48'd9, 20, 0);
    send(8'h00, 4, 2, 48'd12, 21, 0);
    check_regs("R7 disabled");

    // R9 fill to full with N=1
    pulse_clear();
    sample_n = 8'd1;
    for (int p = 0; p < 10; p++) send(8'h00, 3, 4, 48'(p + 3), 30 + p, 0);
    check_regs("R9 full");
    rds(7 * 64, s); chk(s == exp_mem[7][0], "R9 slot7 word0", 64'(s), 64'(exp_mem[7][0]));
    rds(0, s);      chk(s == exp_mem[0][0], "R9 slot0 kept",  64'(s), 64'(exp_mem[0][0]));

    // R9 restart after clear
    pulse_clear();
    send(8'h00, 3, 1, 48'd77, 50, 0);
    check_regs("R9 restart");
    rds(0, s); chk(s == exp_mem[0][0], "R9 slot0 rewritten", 64'(s), 64'(exp_mem[0][0]));

    // R10 clear coinciding with last beat wins
    send(8'h00, 3, 4, 48'd400, 60, 1);
    check_regs("R10 clear at eop");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule